// File: doc/BRIEF.md
# Clock Ratio Control Register with Scattered Fields

This block holds a 16-bit control word that sets two clock ratios. Both ratios are derived from one fast base clock. One ratio drives a processor-domain clock enable and the other drives a peripheral-domain clock enable. Each ratio comes from a 3-bit code whose bits are spread across non-adjacent positions of the word. The block decodes each code into a divisor of 1, 2, 3, 4 or 6. It then produces a one-cycle enable pulse every N base cycles. A divisor of 1 keeps the enable permanently high.

Software writes the word through a simple write strobe and reads it back through `rd_data`. Reserved positions cannot be changed. A write is accepted only when both codes are permitted. It must also satisfy two rules against an external bus reference divisor, given as `bus_div`:

- The processor divisor must not exceed `bus_div`.
- The peripheral divisor must not be below `bus_div`.

A rejected write leaves the word unchanged and raises `wr_err` for one cycle. An accepted ratio reaches an enable generator only at that generator's next terminal count. This keeps every enable period whole.

Top module: `clkratio_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 16'h0100, and both `cpu_en` and `per_en` are high on every cycle (both divisors are 1).
- R2: `rd_data` places the processor code at bits {14,3,2} with bit 14 as MSB, and the peripheral code at bits {13,1,0} with bit 13 as MSB. Bit 8 reads 1, and bits 15, 12:9 and 7:4 read 0.
- R3: The processor code maps 3'b000→1, 3'b001→2, 3'b100→3 and 3'b010→4. `cpu_en` is high for one cycle out of every N base cycles, and is always high when N is 1.
- R4: The peripheral code maps 3'b000→1, 3'b001→2, 3'b100→3, 3'b010→4 and 3'b101→6, with `per_en` pulsing once every N base cycles.
- R5: A write holding any other code in either field leaves `rd_data` unchanged. `wr_err` is then high during exactly the cycle after the write edge.
- R6: A write whose processor divisor is greater than `bus_div` is rejected as in R5.
- R7: A write whose peripheral divisor is less than `bus_div` is rejected as in R5.
- R8: Data written to bits 15, 12:8 and 7:4 has no effect on what `rd_data` returns or on acceptance.
- R9: After an accepted ratio change, the enable gap that is already running completes at the old divisor, and the following gaps use the new divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word being written |
| bus_div | input | BUS_W | Bus reference divisor relative to the base clock |
| rd_data | output | 16 | Control word as read back |
| wr_err | output | 1 | One-cycle flag for a rejected write |
| cpu_en | output | 1 | Processor-domain clock enable |
| per_en | output | 1 | Peripheral-domain clock enable |

## Verification
The bench uses the default parameters: a 3-bit bus divisor and 3-bit divider counters. These are just wide enough for the divide-by-6 code and for bus divisors from 1 to 7. With them, the bench can set every permitted code, including the odd divisors 3 and 6. It can also move `bus_div` so that each of the two frequency rules accepts one write and rejects another. Pulse gaps are measured across a ratio change that is started right after a pulse. This exposes whether the change waits for the terminal count, in both the shorter-to-longer and longer-to-shorter directions.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

    // Field bit positions inside the control word (MSB first)
    localparam int CPU_B2 = 14;
    localparam int CPU_B1 = 3;
    localparam int CPU_B0 = 2;
    localparam int PER_B2 = 13;
    localparam int PER_B1 = 1;
    localparam int PER_B0 = 0;
    localparam int ONE_BIT = 8;

    typedef struct packed {
        logic       ok;
        logic [2:0] div;
    } ratio_t;

    typedef struct packed {
        logic [2:0] cpu;
        logic [2:0] per;
        logic       err;
    } regs_t;

    typedef struct packed {
        logic [2:0] cur;
        logic [7:0] cnt;
    } div_wide_t;

    function automatic ratio_t decode_cpu(input logic [2:0] code);
        ratio_t r;
        r.ok = 1'b1;
        case (code)
            3'b000:  r.div = 3'd1;
            3'b001:  r.div = 3'd2;
            3'b100:  r.div = 3'd3;
            3'b010:  r.div = 3'd4;
            default: begin
                r.ok  = 1'b0;
                r.div = 3'd1;
            end
        endcase
        return r;
    endfunction

    function automatic ratio_t decode_per(input logic [2:0] code);
        ratio_t r;
        r.ok = 1'b1;
        case (code)
            3'b000:  r.div = 3'd1;
            3'b001:  r.div = 3'd2;
            3'b100:  r.div = 3'd3;
            3'b010:  r.div = 3'd4;
            3'b101:  r.div = 3'd6;
            default: begin
                r.ok  = 1'b0;
                r.div = 3'd1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkratio_regs.sv
module clkratio_regs
    import clkratio_pkg::*;
#(
    parameter int BUS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    input  logic [BUS_W-1:0] bus_div,
    output logic [2:0]       cpu_code,
    output logic [2:0]       per_code,
    output logic             wr_err,
    output logic [15:0]      rd_data
);

    regs_t  st_d, st_q;
    ratio_t cpu_dec, per_dec;
    logic [2:0] cpu_in, per_in;
    logic cpu_rule_ok, per_rule_ok, accept;
    logic unused_rsv_bits;

    assign unused_rsv_bits = ^{wr_data[15], wr_data[12:4]};

    always_comb begin
        cpu_in      = {wr_data[CPU_B2], wr_data[CPU_B1], wr_data[CPU_B0]};
        per_in      = {wr_data[PER_B2], wr_data[PER_B1], wr_data[PER_B0]};
        cpu_dec     = decode_cpu(cpu_in);
        per_dec     = decode_per(per_in);
        cpu_rule_ok = int'(cpu_dec.div) <= int'(bus_div);
        per_rule_ok = int'(per_dec.div) >= int'(bus_div);
        accept      = cpu_dec.ok && per_dec.ok && cpu_rule_ok && per_rule_ok;

        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_en) begin
            if (accept) begin
                st_d.cpu = cpu_in;
                st_d.per = per_in;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data          = 16'h0000;
        rd_data[ONE_BIT] = 1'b1;
        rd_data[CPU_B2]  = st_q.cpu[2];
        rd_data[CPU_B1]  = st_q.cpu[1];
        rd_data[CPU_B0]  = st_q.cpu[0];
        rd_data[PER_B2]  = st_q.per[2];
        rd_data[PER_B1]  = st_q.per[1];
        rd_data[PER_B0]  = st_q.per[0];
    end

    assign cpu_code = st_q.cpu;
    assign per_code = st_q.per;
    assign wr_err   = st_q.err;

endmodule

// File: rtl/clkratio_div.sv
module clkratio_div #(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] tgt_div,
    output logic       en_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [2:0]       cur;
        logic [CNT_W-1:0] cnt;
    } dstate_t;

    dstate_t s_d, s_q;
    logic    term;

    always_comb begin
        term = (s_q.cnt == CNT_W'(s_q.cur - 3'd1));
        s_d  = s_q;
        if (term) begin
            s_d.cur = tgt_div;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cur <= 3'd1;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o = term;

endmodule

// File: rtl/clkratio_ctrl.sv
module clkratio_ctrl
    import clkratio_pkg::*;
#(
    parameter int BUS_W = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    input  logic [BUS_W-1:0] bus_div,
    output logic [15:0]      rd_data,
    output logic             wr_err,
    output logic             cpu_en,
    output logic             per_en
);

    localparam int N_DOM = 2;

    logic [2:0] cpu_code, per_code;
    logic [2:0] tgt [N_DOM];
    logic [N_DOM-1:0] en_vec;

    clkratio_regs #(.BUS_W(BUS_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .bus_div  (bus_div),
        .cpu_code (cpu_code),
        .per_code (per_code),
        .wr_err   (wr_err),
        .rd_data  (rd_data)
    );

    always_comb begin
        tgt[0] = decode_cpu(cpu_code).div;
        tgt[1] = decode_per(per_code).div;
    end

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        clkratio_div #(.CNT_W(CNT_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .tgt_div (tgt[g]),
            .en_o    (en_vec[g])
        );
    end

    assign cpu_en = en_vec[0];
    assign per_en = en_vec[1];

endmodule

// File: rtl/clkratio_checker.sv
module clkratio_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_err,
    input logic [15:0] rd_data,
    input logic        cpu_en,
    input logic        per_en
);

    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_data == 16'h0100 && cpu_en && per_en));

    p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[8] && !rd_data[15] && rd_data[12:9] == 4'd0 && rd_data[7:4] == 4'd0);

    p_cpu_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        {rd_data[14], rd_data[3], rd_data[2]} inside {3'b000, 3'b001, 3'b100, 3'b010});

    p_per_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        {rd_data[13], rd_data[1], rd_data[0]} inside {3'b000, 3'b001, 3'b100, 3'b010, 3'b101});

    p_err_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));

    p_reject_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $stable(rd_data));

endmodule

bind clkratio_ctrl clkratio_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_err  (wr_err),
    .rd_data (rd_data),
    .cpu_en  (cpu_en),
    .per_en  (per_en)
);

// File: tb/clkratio_ctrl_test.sv
module clkratio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [2:0]  bus_div = 3'd4;
    logic [15:0] rd_data;
    logic        wr_err, cpu_en, per_en;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        string tag;
        int    val;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    clkratio_ctrl uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .bus_div (bus_div),
        .rd_data (rd_data),
        .wr_err  (wr_err),
        .cpu_en  (cpu_en),
        .per_en  (per_en)
    );

    // driver side: push an expectation
    task automatic push_exp(input string tag, input int val);
        exp_t e;
        e.tag = tag;
        e.val = val;
        exp_q.push_back(e);
    endtask

    // monitor side: pop and compare against an observation
    task automatic pop_cmp(input int act);
        exp_t e;
        e = exp_q.pop_front();
        compared++;
        if (act != e.val) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", e.tag, act, e.val);
        end
    endtask

    function automatic logic pick(input bit sel);
        return sel ? per_en : cpu_en;
    endfunction

    // count negedges from one observed pulse to the next
    task automatic gap_after_pulse(input bit sel, output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!pick(sel));
    endtask

    task automatic measure_gap(input bit sel, output int g);
        while (!pick(sel)) @(negedge clk);
        gap_after_pulse(sel, g);
    endtask

    task automatic do_write(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // write, then check error flag, readback and one-cycle error width
    task automatic write_check(input string tag, input logic [15:0] d,
                               input logic exp_err, input logic [15:0] exp_rd);
        do_write(d);
        push_exp({tag, " err"}, int'(exp_err));
        pop_cmp(int'(wr_err));
        push_exp({tag, " rd"}, int'(exp_rd));
        pop_cmp(int'(rd_data));
        @(negedge clk);
        push_exp({tag, " err clears"}, 0);
        pop_cmp(int'(wr_err));
    endtask

    task automatic gap_check(input string tag, input bit sel, input int n);
        int g;
        push_exp(tag, n);
        measure_gap(sel, g);
        pop_cmp(g);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        push_exp("R1 rd reset", 16'h0100);
        pop_cmp(int'(rd_data));
        push_exp("R1 cpu_en high", 1);
        pop_cmp(int'(cpu_en));
        gap_check("R1 cpu gap", 1'b0, 1);
        gap_check("R1 per gap", 1'b1, 1);

        // R2 R3 R4: cpu /4 (b3), per /4 (b1), bus 4
        bus_div = 3'd4;
        write_check("R2 cpu4 per4", 16'h000A, 1'b0, 16'h010A);
        gap_check("R3 cpu /4", 1'b0, 4);
        gap_check("R4 per /4", 1'b1, 4);

        // R3 R4 odd divisors: cpu 100 (b14) /3, per 101 (b13,b0) /6
        write_check("R2 cpu3 per6", 16'h6001, 1'b0, 16'h6101);
        gap_check("R3 cpu /3", 1'b0, 3);
        gap_check("R4 per /6", 1'b1, 6);

        // R8 reserved bits set, bit 8 cleared
        write_check("R8 reserved", 16'hFEF1, 1'b0, 16'h6101);

        // R5 prohibited codes
        write_check("R5 cpu code 011", 16'h200D, 1'b1, 16'h6101);
        write_check("R5 per code 111", 16'h200B, 1'b1, 16'h6101);
        gap_check("R5 cpu kept /3", 1'b0, 3);

        // R6 cpu slower than bus
        bus_div = 3'd2;
        write_check("R6 cpu3 bus2", 16'h4002, 1'b1, 16'h6101);
        write_check("R6 cpu2 bus2", 16'h0006, 1'b0, 16'h0106);
        gap_check("R6 cpu /2", 1'b0, 2);

        // R7 per faster than bus
        write_check("R7 per1 bus2", 16'h0000, 1'b1, 16'h0106);
        bus_div = 3'd1;
        write_check("R7 per1 bus1", 16'h0000, 1'b0, 16'h0100);
        gap_check("R7 per /1", 1'b1, 1);

        // R9 change /4 -> /2 right after a pulse
        bus_div = 3'd4;
        write_check("R9 setup", 16'h000A, 1'b0, 16'h010A);
        measure_gap(1'b0, g);
        wr_en   = 1'b1;
        wr_data = 16'h0006;
        gap_after_pulse(1'b0, g);
        wr_en = 1'b0;
        push_exp("R9 old gap kept 4", 4);
        pop_cmp(g);
        gap_after_pulse(1'b0, g);
        push_exp("R9 new gap 2", 2);
        pop_cmp(g);

        // R9 change /2 -> /4 right after a pulse
        while (!cpu_en) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 16'h000A;
        gap_after_pulse(1'b0, g);
        wr_en = 1'b0;
        push_exp("R9 old gap kept 2", 2);
        pop_cmp(g);
        gap_after_pulse(1'b0, g);
        push_exp("R9 new gap 4", 4);
        pop_cmp(g);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule